// File: doc/BRIEF.md
# Segmented Up-Counter with Carry-Break Test Mode

A 64-bit synchronous up-counter held as four 16-bit segments. In normal operation the segments are chained, so the whole register behaves as one wide counter: a segment steps only when every segment below it is at all ones. When the test-mode input is high, the links between segments are cut and each segment steps on every enabled cycle by itself. A segment's full range is then covered in 2^16 cycles instead of the 2^64 the chained counter would need.

Only 16 bits of state are visible at a time. A 2-bit select picks one segment for a combinational read port, which also has a flag showing whether that segment is at all ones. A synchronous clear and a synchronous enable control counting in both modes.

Top module: `part_counter`

## Requirements
- R1: While rst_ni is low, all four segments are zero.
- R2: With test_mode_i low, enable_i high and clear_i low, the 64-bit value advances by one per clock. Segment k+1 steps only when segments 0..k are all 0xFFFF, and all ones wraps to zero.
- R3: clear_i high zeroes every segment at the next edge and takes priority over enable_i.
- R4: With enable_i low and clear_i low, no segment changes in either mode.
- R5: With test_mode_i high, enable_i high and clear_i low, every segment steps by one on each edge, regardless of the other segments. A segment wraps 0xFFFF to 0x0000 without affecting any other segment.
- R6: rdata_o shows segment sel_i combinationally. sel_i = 0 selects bits 15:0, the least significant segment, and sel_i = 3 selects bits 63:48.
- R7: tc_o is high exactly when the selected segment holds 0xFFFF.
- R8: A change of test_mode_i leaves the segment contents unchanged. The new mode governs counting from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear, highest priority |
| enable_i | input | 1 | Count enable |
| test_mode_i | input | 1 | 1 = segments count independently, 0 = chained |
| sel_i | input | 2 | Segment select for the read port |
| rdata_o | output | 16 | Value of the selected segment |
| tc_o | output | 1 | Selected segment is at all ones |

## Verification
Carry into the upper segments and the full 64-bit wrap are the hardest states to reach from the ports, because chained counting needs up to 2^64 cycles to get there. The stimulus reaches them through test mode itself. It runs 65535 or 65534 parallel steps to preload every segment to 0xFFFF or 0xFFFE. It then switches to normal mode for one or two steps, which shows the full wrap to zero and a carry that stops at segment 1. One further test-mode step makes segment 1 wrap on its own while segments 2 and 3 step without any carry in.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  parameter int unsigned SEG_W   = 16;
  parameter int unsigned NUM_SEG = 4;
endpackage

// File: rtl/pcnt_segment.sv
module pcnt_segment #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         full_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (clr_i) q <= '0;
    else if (inc_i) q <= q + 1'b1;
  end

  assign val_o  = q;
  assign full_o = &q;
endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
  parameter int unsigned N = 4
) (
  input  logic         en_i,
  input  logic         test_i,
  input  logic [N-1:0] full_i,
  output logic [N-1:0] inc_o
);
  assign inc_o[0] = en_i;

  for (genvar k = 1; k < N; k++) begin : g_link
    // test mode breaks the chain: every segment sees the raw enable
    assign inc_o[k] = test_i ? en_i : (inc_o[k-1] & full_i[k-1]);
  end
endmodule

// File: rtl/pcnt_rd_mux.sv
module pcnt_rd_mux #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 16,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] flat_i,
  input  logic [N-1:0]   full_i,
  input  logic [SW-1:0]  sel_i,
  output logic [W-1:0]   rdata_o,
  output logic           tc_o
);
  always_comb begin
    rdata_o = '0;
    tc_o    = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SW'(k)) begin
        rdata_o = flat_i[k*W +: W];
        tc_o    = full_i[k];
      end
    end
  end
endmodule

// File: rtl/part_counter.sv
module part_counter
  import pcnt_pkg::*;
#(
  parameter int unsigned SW_P = SEG_W,
  parameter int unsigned NS_P = NUM_SEG,
  localparam int unsigned SEL_W = (NS_P > 1) ? $clog2(NS_P) : 1,
  localparam int unsigned TOT_W = SW_P * NS_P
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             enable_i,
  input  logic             test_mode_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SW_P-1:0]  rdata_o,
  output logic             tc_o
);
  logic [NS_P-1:0]  inc;
  logic [NS_P-1:0]  full;
  logic [TOT_W-1:0] cnt_flat;

  pcnt_carry #(.N(NS_P)) u_carry (
    .en_i   (enable_i),
    .test_i (test_mode_i),
    .full_i (full),
    .inc_o  (inc)
  );

  for (genvar k = 0; k < NS_P; k++) begin : g_seg
    pcnt_segment #(.W(SW_P)) u_seg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .inc_i  (inc[k]),
      .val_o  (cnt_flat[k*SW_P +: SW_P]),
      .full_o (full[k])
    );
  end

  pcnt_rd_mux #(.N(NS_P), .W(SW_P)) u_mux (
    .flat_i  (cnt_flat),
    .full_i  (full),
    .sel_i   (sel_i),
    .rdata_o (rdata_o),
    .tc_o    (tc_o)
  );
endmodule

// File: rtl/part_counter_chk.sv
module part_counter_chk #(
  parameter int unsigned SW_P  = 16,
  parameter int unsigned NS_P  = 4,
  parameter int unsigned SEL_W = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 clear_i,
  input logic                 enable_i,
  input logic                 test_mode_i,
  input logic [SEL_W-1:0]     sel_i,
  input logic [SW_P-1:0]      rdata_o,
  input logic                 tc_o,
  input logic [NS_P*SW_P-1:0] cnt_flat
);
  a_r3_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_flat == '0));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !enable_i) |=> $stable(cnt_flat));

  a_r2_chain_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && enable_i && !test_mode_i) |=> (cnt_flat == $past(cnt_flat) + 1'b1));

  a_r5_top_seg_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && enable_i && test_mode_i) |=>
      (cnt_flat[NS_P*SW_P-1 -: SW_P] == $past(cnt_flat[NS_P*SW_P-1 -: SW_P]) + 1'b1));

  a_r7_tc_means_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (rdata_o == '1));

  a_r7_full_means_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o == '1) |-> tc_o);
endmodule

bind part_counter part_counter_chk #(.SW_P(SW_P), .NS_P(NS_P), .SEL_W(SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .enable_i    (enable_i),
  .test_mode_i (test_mode_i),
  .sel_i       (sel_i),
  .rdata_o     (rdata_o),
  .tc_o        (tc_o),
  .cnt_flat    (cnt_flat)
);

// File: tb/part_counter_tb.sv
module part_counter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        enable_i = 1'b0;
  logic        test_mode_i = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic [15:0] rdata_o;
  logic        tc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  part_counter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .enable_i(enable_i),
    .test_mode_i(test_mode_i), .sel_i(sel_i), .rdata_o(rdata_o), .tc_o(tc_o)
  );

  task automatic chk_seg(input int k, input logic [15:0] exp, input string req);
    sel_i = 2'(k);
    #1;
    checks++;
    if (rdata_o !== exp) begin
      errors++;
      $display("FAIL %s seg%0d rdata act=%h exp=%h", req, k, rdata_o, exp);
    end
    checks++;
    if (tc_o !== (exp == 16'hFFFF)) begin
      errors++;
      $display("FAIL R7 (%s) seg%0d tc act=%b exp=%b", req, k, tc_o, exp == 16'hFFFF);
    end
  endtask

  task automatic chk_all(input logic [15:0] e0, e1, e2, e3, input string req);
    chk_seg(0, e0, req); chk_seg(1, e1, req);
    chk_seg(2, e2, req); chk_seg(3, e3, req);
  endtask

  // n enabled edges in the given mode; inputs change away from edges
  task automatic run(input bit mode, input int n);
    @(negedge clk_i);
    test_mode_i = mode;
    enable_i    = 1'b1;
    repeat (n) @(posedge clk_i);
    #1 enable_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_clear(input bit with_en);
    @(negedge clk_i);
    clear_i  = 1'b1;
    enable_i = with_en;
    @(posedge clk_i);
    #1 clear_i = 1'b0;
    enable_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk_all(16'h0, 16'h0, 16'h0, 16'h0, "R1");
  endtask

  task automatic t_normal_small;
    run(1'b0, 5);
    chk_all(16'h5, 16'h0, 16'h0, 16'h0, "R2");
    chk_seg(0, 16'h5, "R6");
  endtask

  task automatic t_hold;
    @(negedge clk_i);
    test_mode_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk_all(16'h5, 16'h0, 16'h0, 16'h0, "R4");
    test_mode_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk_all(16'h5, 16'h0, 16'h0, 16'h0, "R4");
  endtask

  task automatic t_clear;
    do_clear(1'b1);
    chk_all(16'h0, 16'h0, 16'h0, 16'h0, "R3");
  endtask

  task automatic t_test_small;
    run(1'b1, 3);
    chk_all(16'h3, 16'h3, 16'h3, 16'h3, "R5");
    // mode switch keeps contents, then chained counting resumes
    run(1'b0, 2);
    chk_all(16'h5, 16'h3, 16'h3, 16'h3, "R8");
    do_clear(1'b0);
  endtask

  task automatic t_full_wrap;
    run(1'b1, 65535);
    chk_all(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R5");
    run(1'b0, 1);
    chk_all(16'h0, 16'h0, 16'h0, 16'h0, "R2");
  endtask

  task automatic t_partial_carry;
    run(1'b1, 65534);
    chk_all(16'hFFFE, 16'hFFFE, 16'hFFFE, 16'hFFFE, "R5");
    run(1'b0, 1);
    chk_all(16'hFFFF, 16'hFFFE, 16'hFFFE, 16'hFFFE, "R2");
    run(1'b0, 1);
    chk_all(16'h0, 16'hFFFF, 16'hFFFE, 16'hFFFE, "R2");
    run(1'b1, 1);
    chk_all(16'h1, 16'h0, 16'hFFFF, 16'hFFFF, "R5");
  endtask

  initial begin
    #23;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_normal_small();
    t_hold();
    t_clear();
    t_test_small();
    t_full_wrap();
    t_partial_carry();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 180000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule